// File: doc/BRIEF.md
# Addressing-Mode Bus Cycle Sequencer

This block drives the memory bus of a small 8-bit accumulator-style processor. It handles a handful of operand addressing schemes: immediate, page-zero direct, page-zero plus X, and pointer-in-page-zero plus Y. Instruction length is not looked up in a table. It comes from the accesses themselves: the sequencer issues one real read or write on every clock. That includes the throw-away read made while a page carry is still being resolved, and the write-back of the unmodified value during a read-modify-write.

Memory is assumed to answer reads in the same cycle. An external decoder turns the opcode byte on `rdata` into the three decode fields while the opcode fetch is under way, and the sequencer latches them at the end of that cycle. The modify step of a read-modify-write is a fixed function chosen by a parameter: increment, decrement or shift left. Interrupt requests are sampled one cycle before an instruction completes, and the interrupt-disable flag changes only when its instruction completes. The bus here is a plain synchronous memory port that cannot stall, so it carries no valid/ready handshake and back-pressure does not apply.

Top module: `amode_bus_seq`

## Requirements
- R1: The block makes exactly one access per cycle. While reset is held, the bus reads at `RESET_PC` with `done` and `irq_taken` low. The first access of every instruction is a read at the program counter, which advances by one for the opcode and by one for the operand byte.
- R2: Decode fields are latched in the opcode-fetch cycle. `dec_mode` uses 0 immediate, 1 page zero, 2 page zero + X, 3 indirect + Y. `dec_kind` uses 0 read, 1 write, 2 read-modify-write, 3 treated as read. `dec_flag` uses 0 none, 1 clear interrupt-disable, 2 set it.
- R3: Immediate mode takes 2 cycles, and its last access reads the operand byte at the program counter. Its access kind is ignored: it never writes.
- R4: Page-zero mode takes 3 cycles, with the final access at {0x00, operand}. A read-modify-write takes 5 cycles.
- R5: Page-zero + X takes 4 cycles. The third cycle is a dummy read at {0x00, operand}, and the final access is at {0x00, (operand + X) mod 256}. A read-modify-write takes 6 cycles.
- R6: Indirect + Y reads the pointer low byte at {0x00, operand}, then the high byte at {0x00, (operand + 1) mod 256}. The next cycle accesses {high, (low + Y) mod 256}.
- R7: If low + Y carries, the access at {high, low + Y} is a dummy read. One more cycle then accesses {high + 1, low + Y}, so an indirect read or write takes 5 cycles without a carry and 6 with one.
- R8: A write has the same timing as a read. Its final access writes `st_data` instead of reading.
- R9: A read-modify-write reads the operand, writes the unmodified value back in the next cycle, then writes the modified value to the same address. With `MODIFY_OP`=0 the modified value is the old value + 1, modulo 256.
- R10: `done` is high in exactly the last cycle of each instruction. `irq_taken` is high with `done` only when `irq` was high and interrupt-disable was clear in the cycle before it.
- R11: Interrupt-disable is set by reset and changes only at the end of the last cycle of a clear or set instruction. A request pending across a clear is therefore taken at the end of the following instruction, even if that instruction sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_mode | input | 2 | Addressing-mode decode of the opcode on `rdata` |
| dec_kind | input | 2 | Access-kind decode of the opcode on `rdata` |
| dec_flag | input | 2 | Interrupt-disable update decode of the opcode |
| idx_x | input | DW | X index register value |
| idx_y | input | DW | Y index register value |
| st_data | input | DW | Value stored by write instructions |
| rdata | input | DW | Read data, valid in the cycle of the read |
| irq | input | 1 | Level interrupt request |
| addr | output | 2*DW | Bus address |
| bus_rd | output | 1 | 1 = read cycle, 0 = write cycle |
| wdata | output | DW | Write data, meaningful when `bus_rd` is 0 |
| done | output | 1 | High in the last cycle of an instruction |
| irq_taken | output | 1 | Interrupt accepted at this instruction boundary |

## Verification
The bench builds the block with DW=8, `RESET_PC`=0x0300 and `MODIFY_OP`=0 (increment). Pointers in the bench memory reach pages 4 to 6. A single 2 KiB array therefore holds both uncorrected and corrected page-cross targets, so the dummy read and the page-high fixup can each be seen at their own address. An increment that turns 0xFF into 0x00 and a page-zero + X sum that wraps past 0xFF are both in range. Cycle-by-cycle control of `irq` lets a request that appears only in the final cycle be told apart from one that appears only in the cycle before it.

// File: rtl/abs_pkg.sv
package abs_pkg;
  typedef enum logic [1:0] {
    AM_IMM  = 2'd0,
    AM_ZP   = 2'd1,
    AM_ZPX  = 2'd2,
    AM_INDY = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    AK_READ  = 2'd0,
    AK_WRITE = 2'd1,
    AK_RMW   = 2'd2,
    AK_RSVD  = 2'd3
  } akind_e;

  typedef enum logic [1:0] {
    FO_NONE  = 2'd0,
    FO_CLEAR = 2'd1,
    FO_SET   = 2'd2,
    FO_RSVD  = 2'd3
  } flagop_e;

  // Bus-cycle states; ST_GUESS is the indirect access made before the page carry is known.
  typedef enum logic [3:0] {
    ST_FETCH = 4'd0,
    ST_OPND  = 4'd1,
    ST_IDX   = 4'd2,
    ST_PLO   = 4'd3,
    ST_PHI   = 4'd4,
    ST_GUESS = 4'd5,
    ST_EXEC  = 4'd6,
    ST_WBACK = 4'd7,
    ST_WNEW  = 4'd8
  } bstate_e;
endpackage

// File: rtl/abs_fsm.sv
module abs_fsm
  import abs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dec_mode,
  input  logic [1:0] dec_kind,
  input  logic [1:0] dec_flag,
  input  logic       carry_now,
  input  logic       carry_q,
  output bstate_e    state,
  output amode_e     mode_q,
  output akind_e     kind_q,
  output flagop_e    flag_q,
  output logic       last,
  output logic       penult
);
  bstate_e nxt;
  akind_e  kind_norm;
  logic    rmw;

  // Immediate never touches memory beyond its operand; the reserved kind reads.
  always_comb begin
    if (amode_e'(dec_mode) == AM_IMM || akind_e'(dec_kind) == AK_RSVD) kind_norm = AK_READ;
    else kind_norm = akind_e'(dec_kind);
  end

  assign rmw = (kind_q == AK_RMW);

  always_comb begin
    nxt    = ST_FETCH;
    last   = 1'b0;
    penult = 1'b0;
    unique case (state)
      ST_FETCH: begin
        nxt    = ST_OPND;
        penult = (amode_e'(dec_mode) == AM_IMM);
      end
      ST_OPND: begin
        unique case (mode_q)
          AM_IMM:  last = 1'b1;
          AM_ZP:   begin nxt = ST_EXEC; penult = !rmw; end
          AM_ZPX:  nxt = ST_IDX;
          AM_INDY: nxt = ST_PLO;
          default: last = 1'b1;
        endcase
      end
      ST_IDX: begin
        nxt    = ST_EXEC;
        penult = !rmw;
      end
      ST_PLO:  nxt = ST_PHI;
      ST_PHI: begin
        nxt    = ST_GUESS;
        penult = !rmw && !carry_now;
      end
      ST_GUESS: begin
        if (carry_q) begin
          nxt    = ST_EXEC;
          penult = !rmw;
        end else if (rmw) begin
          nxt = ST_WBACK;
        end else begin
          last = 1'b1;
        end
      end
      ST_EXEC: begin
        if (rmw) nxt = ST_WBACK;
        else last = 1'b1;
      end
      ST_WBACK: begin
        nxt    = ST_WNEW;
        penult = 1'b1;
      end
      ST_WNEW: last = 1'b1;
      default: last = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_FETCH;
      mode_q <= AM_IMM;
      kind_q <= AK_READ;
      flag_q <= FO_NONE;
    end else begin
      state <= nxt;
      if (state == ST_FETCH) begin
        mode_q <= amode_e'(dec_mode);
        kind_q <= kind_norm;
        flag_q <= flagop_e'(dec_flag);
      end
    end
  end

  // R10: the sampling cycle is always directly followed by the final cycle
  p_penult_then_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    penult |=> last);

  // R3: an immediate instruction ends right after its opcode fetch
  p_imm_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && amode_e'(dec_mode) == AM_IMM) |=> last);
endmodule

// File: rtl/abs_path.sv
module abs_path
  import abs_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          MODIFY_OP = 0,
  parameter logic [2*DW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bstate_e       state,
  input  amode_e        mode_q,
  input  akind_e        kind_q,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] st_data,
  output logic [2*DW-1:0] addr,
  output logic          bus_rd,
  output logic [DW-1:0] wdata,
  output logic          carry_now,
  output logic          carry_q
);
  localparam int AW = 2 * DW;
  localparam int HW = AW - DW;

  logic [AW-1:0] pc, ea;
  logic [DW-1:0] ptr_lo, data_q, idx_sum, mod_val;
  logic          exec_here;

  assign {carry_now, idx_sum} = {1'b0, ptr_lo} + {1'b0, idx_y};
  assign exec_here = (state == ST_EXEC) || (state == ST_GUESS && !carry_q);

  generate
    if (MODIFY_OP == 1) begin : g_dec
      assign mod_val = data_q - DW'(1);
    end else if (MODIFY_OP == 2) begin : g_shl
      assign mod_val = {data_q[DW-2:0], 1'b0};
    end else begin : g_inc
      assign mod_val = data_q + DW'(1);
    end
  endgenerate

  always_comb begin
    addr = ea;
    if (state == ST_FETCH || state == ST_OPND) addr = pc;
  end

  always_comb begin
    if (exec_here) bus_rd = (kind_q != AK_WRITE);
    else bus_rd = !(state == ST_WBACK || state == ST_WNEW);
  end

  always_comb begin
    unique case (state)
      ST_WBACK: wdata = data_q;
      ST_WNEW:  wdata = mod_val;
      default:  wdata = st_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= RESET_PC;
      ea      <= '0;
      ptr_lo  <= '0;
      data_q  <= '0;
      carry_q <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH: pc <= pc + AW'(1);
        ST_OPND: begin
          pc <= pc + AW'(1);
          ea <= {{HW{1'b0}}, rdata};
        end
        ST_IDX: ea[DW-1:0] <= ea[DW-1:0] + idx_x;
        ST_PLO: begin
          ptr_lo     <= rdata;
          ea[DW-1:0] <= ea[DW-1:0] + DW'(1);
        end
        ST_PHI: begin
          ea      <= {rdata, idx_sum};
          carry_q <= carry_now;
        end
        ST_GUESS: if (carry_q) ea[AW-1:DW] <= ea[AW-1:DW] + HW'(1);
        default: ;
      endcase
      if (exec_here && kind_q == AK_RMW) data_q <= rdata;
    end
  end

  // R9: back-to-back writes only occur in read-modify-write, always to one address
  p_rmw_same_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && $past(!bus_rd)) |-> $stable(addr));

  // R7: the fixup access moves to the next page at the same low byte
  p_fix_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GUESS && carry_q) |=>
      (addr[AW-1:DW] == HW'($past(addr[AW-1:DW]) + HW'(1)) &&
       addr[DW-1:0] == $past(addr[DW-1:0])));

  // R5: page-zero modes never leave page zero
  p_zero_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && (mode_q == AM_ZP || mode_q == AM_ZPX)) |-> (addr[AW-1:DW] == '0));
endmodule

// File: rtl/abs_irq.sv
module abs_irq
  import abs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    penult,
  input  logic    last,
  input  flagop_e flag_q,
  input  logic    irq,
  output logic    irq_taken,
  output logic    iflag
);
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      iflag <= 1'b1;
    end else begin
      if (penult) seen <= irq && !iflag;
      else if (last) seen <= 1'b0;
      if (last) begin
        if (flag_q == FO_CLEAR) iflag <= 1'b0;
        else if (flag_q == FO_SET) iflag <= 1'b1;
      end
    end
  end

  assign irq_taken = last && seen;

  // R11: the disable flag moves only at an instruction boundary
  p_flag_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(iflag) |-> $past(last));

  // R10: an accepted interrupt was requested and enabled one cycle earlier
  p_taken_sampled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> $past(irq && !iflag));
endmodule

// File: rtl/amode_bus_seq.sv
module amode_bus_seq
  import abs_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MODIFY_OP = 0,
  parameter logic [2*DW-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      dec_mode,
  input  logic [1:0]      dec_kind,
  input  logic [1:0]      dec_flag,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  input  logic [DW-1:0]   st_data,
  input  logic [DW-1:0]   rdata,
  input  logic            irq,
  output logic [2*DW-1:0] addr,
  output logic            bus_rd,
  output logic [DW-1:0]   wdata,
  output logic            done,
  output logic            irq_taken
);
  bstate_e state;
  amode_e  mode_q;
  akind_e  kind_q;
  flagop_e flag_q;
  logic    last, penult, carry_now, carry_q, iflag;

  abs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .dec_mode(dec_mode), .dec_kind(dec_kind), .dec_flag(dec_flag),
    .carry_now(carry_now), .carry_q(carry_q),
    .state(state), .mode_q(mode_q), .kind_q(kind_q), .flag_q(flag_q),
    .last(last), .penult(penult)
  );

  abs_path #(.DW(DW), .MODIFY_OP(MODIFY_OP), .RESET_PC(RESET_PC)) u_path (
    .clk(clk), .rst_n(rst_n),
    .state(state), .mode_q(mode_q), .kind_q(kind_q),
    .rdata(rdata), .idx_x(idx_x), .idx_y(idx_y), .st_data(st_data),
    .addr(addr), .bus_rd(bus_rd), .wdata(wdata),
    .carry_now(carry_now), .carry_q(carry_q)
  );

  abs_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .penult(penult), .last(last), .flag_q(flag_q), .irq(irq),
    .irq_taken(irq_taken), .iflag(iflag)
  );

  assign done = last;

  // R1: an instruction boundary is always followed by an opcode read
  p_fetch_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> bus_rd);
endmodule

// File: tb/sim_amode_bus_seq.sv
module sim_amode_bus_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] START = 16'h0300;
  localparam int NV = 14;

  typedef struct packed {
    logic [7:0]  op, opr, x, y, st, cyc;
    logic [15:0] ea;
    logic [7:0]  rw, wd, old;
    logic [15:0] dmy;
  } vec_t;

  // op, opr, x, y, st, cycles, final addr (FFFF = operand addr), final rw, wdata, old, dummy addr
  localparam logic [103:0] VECS [NV] = '{
    {8'h00,8'h12,8'h00,8'h00,8'h00,8'd2,16'hFFFF,8'h01,8'h00,8'h00,16'h0000}, // R3
    {8'h01,8'h30,8'h00,8'h00,8'h00,8'd3,16'h0030,8'h01,8'h00,8'h00,16'h0000}, // R4
    {8'h05,8'h31,8'h00,8'h00,8'hA5,8'd3,16'h0031,8'h00,8'hA5,8'h00,16'h0000}, // R8
    {8'h09,8'h20,8'h00,8'h00,8'h00,8'd5,16'h0020,8'h00,8'h80,8'h7F,16'h0000}, // R9
    {8'h02,8'h10,8'h05,8'h00,8'h00,8'd4,16'h0015,8'h01,8'h00,8'h00,16'h0000}, // R5
    {8'h02,8'hF0,8'h20,8'h00,8'h00,8'd4,16'h0010,8'h01,8'h00,8'h00,16'h0000}, // R5 wrap
    {8'h0A,8'h21,8'h01,8'h00,8'h00,8'd6,16'h0022,8'h00,8'h00,8'hFF,16'h0000}, // R9
    {8'h03,8'h40,8'h00,8'h05,8'h00,8'd5,16'h04F5,8'h01,8'h00,8'h00,16'h0000}, // R6
    {8'h03,8'h40,8'h00,8'h20,8'h00,8'd6,16'h0510,8'h01,8'h00,8'h00,16'h0410}, // R7
    {8'h07,8'h40,8'h00,8'h10,8'h3C,8'd6,16'h0500,8'h00,8'h3C,8'h00,16'h0400}, // R7 R8
    {8'h07,8'h40,8'h00,8'h01,8'h99,8'd5,16'h04F1,8'h00,8'h99,8'h00,16'h0000}, // R8
    {8'h03,8'hFF,8'h00,8'h02,8'h00,8'd5,16'h0612,8'h01,8'h00,8'h00,16'h0000}, // R6 wrap
    {8'h0B,8'h40,8'h00,8'h11,8'h00,8'd8,16'h0501,8'h00,8'h42,8'h41,16'h0401}, // R9
    {8'h04,8'h77,8'h00,8'h00,8'hEE,8'd2,16'hFFFF,8'h01,8'h00,8'h00,16'h0000}  // R3 kind ignored
  };

  logic clk = 1'b0, rst_n = 1'b0, irq = 1'b0;
  logic [7:0] idx_x = '0, idx_y = '0, st_data = '0, rdata, wdata;
  logic [1:0] dec_mode, dec_kind, dec_flag;
  logic [15:0] addr;
  logic bus_rd, done, irq_taken;
  logic [7:0] mem [0:2047];

  int checks = 0, failures = 0, cycles = 0;
  logic [15:0] tr_addr [16];
  logic        tr_rw   [16];
  logic [7:0]  tr_wd   [16];
  logic        tr_tk;
  logic [15:0] pc_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  // R2: decode fields from the opcode byte: [1:0] mode, [3:2] kind, [5:4] flag op
  assign rdata    = mem[addr[10:0]];
  assign dec_mode = rdata[1:0];
  assign dec_kind = rdata[3:2];
  assign dec_flag = rdata[5:4];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && !bus_rd) mem[addr[10:0]] <= wdata;
  end

  amode_bus_seq #(.DW(8), .MODIFY_OP(0), .RESET_PC(START)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_mode(dec_mode), .dec_kind(dec_kind), .dec_flag(dec_flag),
    .idx_x(idx_x), .idx_y(idx_y), .st_data(st_data), .rdata(rdata), .irq(irq),
    .addr(addr), .bus_rd(bus_rd), .wdata(wdata), .done(done), .irq_taken(irq_taken)
  );

  task automatic chk(input logic ok, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Runs one instruction from its fetch cycle; irq is driven per cycle from mask.
  task automatic run(input logic [15:0] mask, output int n);
    logic d;
    n = 0;
    do begin
      irq = mask[n];
      #1;
      tr_addr[n] = addr; tr_rw[n] = bus_rd; tr_wd[n] = wdata; tr_tk = irq_taken;
      d = done;
      n++;
      @(negedge clk);
    end while (!d && n < 16);
  endtask

  task automatic put(input logic [7:0] op, input logic [7:0] opr);
    mem[pc_m[10:0]] = op;
    mem[pc_m[10:0] + 11'd1] = opr;
    pc_m = pc_m + 16'd2;
  endtask

  initial begin
    int n;
    vec_t v;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    mem[16'h30] = 8'h55; mem[16'h20] = 8'h7F; mem[16'h22] = 8'hFF;
    mem[16'h40] = 8'hF0; mem[16'h41] = 8'h04;
    mem[16'hFF] = 8'h10; mem[16'h00] = 8'h06;
    mem[16'h501] = 8'h41;
    pc_m = START;
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      put(v.op, v.opr);
    end
    put(8'h10, 8'h00); put(8'h20, 8'h00); put(8'h00, 8'h00);
    put(8'h10, 8'h00); put(8'h01, 8'h30); put(8'h00, 8'h00);

    repeat (3) @(negedge clk);
    #1;
    chk(addr == START && bus_rd && !done && !irq_taken, "R1 reset state", addr, START);
    rst_n = 1'b1;
    #1;
    @(negedge clk);
    // release happened mid-cycle before this edge; align to the fetch of the first instruction
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;

    pc_m = START;
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      idx_x = v.x; idx_y = v.y; st_data = v.st;
      run(16'h0000, n);
      chk(tr_addr[0] == pc_m && tr_rw[0], $sformatf("R1 fetch addr vec %0d", i), tr_addr[0], pc_m);
      chk(n == int'(v.cyc), $sformatf("R3 R4 R5 R7 cycles vec %0d", i), 16'(n), 16'(v.cyc));
      chk(tr_addr[n-1] == ((v.ea == 16'hFFFF) ? pc_m + 16'd1 : v.ea),
          $sformatf("R6 final addr vec %0d", i), tr_addr[n-1], v.ea);
      chk(tr_rw[n-1] == v.rw[0], $sformatf("R8 final direction vec %0d", i), 16'(tr_rw[n-1]), 16'(v.rw[0]));
      if (!v.rw[0])
        chk(tr_wd[n-1] == v.wd, $sformatf("R8 R9 write data vec %0d", i), 16'(tr_wd[n-1]), 16'(v.wd));
      if (v.op[3:2] == 2'd2 && n >= 3) begin
        chk(tr_rw[n-3] && !tr_rw[n-2] && tr_wd[n-2] == v.old && tr_addr[n-3] == tr_addr[n-1],
            $sformatf("R9 read then old write-back vec %0d", i), 16'(tr_wd[n-2]), 16'(v.old));
      end
      if (v.dmy != 16'h0000)
        chk(tr_addr[4] == v.dmy && tr_rw[4], $sformatf("R7 dummy read vec %0d", i), tr_addr[4], v.dmy);
      if (v.op[1:0] == 2'd2)
        chk(tr_addr[2] == {8'h00, v.opr} && tr_rw[2], $sformatf("R5 index dummy vec %0d", i),
            tr_addr[2], {8'h00, v.opr});
      pc_m = pc_m + 16'd2;
    end
    chk(mem[16'h31] == 8'hA5, "R8 stored byte", 16'(mem[16'h31]), 16'h00A5);
    chk(mem[16'h22] == 8'h00, "R9 increment wraps", 16'(mem[16'h22]), 16'h0000);
    chk(mem[16'h501] == 8'h42, "R9 modified byte", 16'(mem[16'h501]), 16'h0042);
    chk(mem[16'h12] == 8'h00 && mem[16'h77] == 8'h00, "R3 immediate wrote nothing", 16'(mem[16'h77]), 16'h0000);

    // R11: request held across clear, then set
    run(16'h0003, n); chk(!tr_tk, "R11 not taken during clear", 16'(tr_tk), 16'h0);
    run(16'h0003, n); chk(tr_tk, "R11 taken at end of set", 16'(tr_tk), 16'h1);
    run(16'h0003, n); chk(!tr_tk, "R11 flag set blocks", 16'(tr_tk), 16'h0);
    run(16'h0000, n); chk(!tr_tk, "R11 clear without request", 16'(tr_tk), 16'h0);
    // R10: request only in the final cycle is missed, only in the cycle before it is taken
    run(16'h0004, n); chk(!tr_tk && n == 3, "R10 last-cycle request ignored", 16'(tr_tk), 16'h0);
    run(16'h0001, n); chk(tr_tk && n == 2, "R10 sampled one cycle before done", 16'(tr_tk), 16'h1);
    irq = 1'b0;
    finish_run();
  end

  initial begin
    wait (cycles > 5000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<5000", cycles);
    finish_run();
  end
endmodule